// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block lets a clocked host reach an external asynchronous static RAM of 256K words by 16 bits. The host presents one request at a time: an 18-bit word address, a read/write flag, 16 bits of write data and a 2-bit byte-enable. It holds the request until a one-cycle acknowledge comes back. Bit 0 of the byte-enable selects data bits 7:0, the lower lane. Bit 1 selects bits 15:8, the upper lane. The block drives the memory's active-low primary select, active-high secondary select, output enable, write enable and two active-low lane strobes. It also produces the write data and an enable for the tri-state data pad.

Every interval is a whole number of clock cycles. Each count is the required time in picoseconds divided by the clock period, rounded up, with a minimum of 1. With the default 5 ns clock and 45 ns parts, these counts follow:

- a read holds output enable low for 9 cycles;
- a write holds write enable low for 8 cycles, then adds 1 hold cycle;
- the bus float gap after a read is 3 cycles;
- the recovery after leaving retention is 9 cycles.

A `sleep` input parks the memory in its low-voltage retention state by pulling the secondary select low.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the primary select, write enable, output enable and both lane strobes are high, pad drive is off and acknowledge is low.
- R2: A read holds primary select low, secondary select high, write enable high and output enable low for N_RD consecutive cycles (9 by default). Both lane strobes stay low throughout, whatever the byte-enable.
- R3: A read returns the full 16-bit word that the memory presents on the last cycle of its window.
- R4: A write with a non-zero byte-enable holds write enable low for N_WP consecutive cycles (8 by default), with primary select low and output enable high. The lower strobe is low exactly when byte-enable bit 0 is set, and the upper strobe exactly when bit 1 is set.
- R5: Pad drive turns on only after write enable has already been low for one cycle, and it stays on for every later low cycle of that write.
- R6: A write ends when write enable, primary select and both strobes rise on the same edge. The address and pad drive hold for that next cycle.
- R7: A write with byte-enable 00 drives write enable low on no cycle, leaves the memory contents unchanged and is still acknowledged.
- R8: Pad drive is never on while output enable is low. After a read, the memory stays deselected for at least N_HZ cycles (3 by default) before the next access.
- R9: While `sleep` is high in idle, the secondary select is low, the primary select is high and requests wait. After `sleep` falls, no access starts for at least N_RDR cycles (9 by default).
- R10: Every accepted request yields exactly one acknowledge pulse, one cycle wide. Address and memory select stay stable for the whole time the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Request to enter the retention state |
| req | input | 1 | Access request, held until acknowledge |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW (18) | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte-enable, bit 0 lower lane, bit 1 upper lane |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid from acknowledge |
| mem_addr | output | AW (18) | Memory address |
| mem_cs1_n | output | 1 | Primary select, active low |
| mem_cs2 | output | 1 | Secondary select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data toward the pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from the pad |

## Verification
The assertions assume the host keeps each request and its fields stable until acknowledge and drops `req` in the acknowledge cycle. They also assume `sleep` is never changed in the middle of an access in a way the checks depend on. The bench keeps to both: its driver task raises a request on a falling edge, waits for acknowledge, then drops it, and it toggles `sleep` only while the block is idle. The memory model in the bench drives the read bus only while select, output enable and write enable call for a read. It commits a write on the cycle that write enable rises, so it follows the same convention as the assertions.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW       = 18,
  parameter int CW       = 16,
  parameter int CLK_PS   = 5000,
  parameter int T_RC_PS  = 45000,
  parameter int T_AA_PS  = 45000,
  parameter int T_OE_PS  = 20000,
  parameter int T_WC_PS  = 45000,
  parameter int T_WP_PS  = 35000,
  parameter int T_AW_PS  = 35000,
  parameter int T_DS_PS  = 20000,
  parameter int T_HZ_PS  = 15000,
  parameter int T_RDR_PS = 45000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic [1:0]    be,
  output logic          ack,
  output logic [15:0]   rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);

  function automatic int cyc(input int t_ps);
    int c;
    c = (t_ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = mx(mx(cyc(T_RC_PS), cyc(T_AA_PS)), cyc(T_OE_PS));
  localparam int N_WP  = mx(mx(cyc(T_WP_PS), cyc(T_AW_PS)),
                            mx(cyc(T_DS_PS) + 1, cyc(T_WC_PS) - 1));
  localparam int N_HZ  = cyc(T_HZ_PS);
  localparam int N_RDR = cyc(T_RDR_PS);

  typedef enum logic [2:0] {
    S_IDLE, S_RET, S_RECOV, S_RD, S_RREL, S_WLO, S_WDRV, S_WHOLD
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    msk_q;
  logic          act;

  assign act       = (st == S_RD) || (st == S_WLO) || (st == S_WDRV);
  assign mem_cs1_n = !act;
  assign mem_cs2   = (st != S_RET);
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = !((st == S_WLO) || (st == S_WDRV));
  assign mem_lb_n  = !(act && msk_q[0]);
  assign mem_ub_n  = !(act && msk_q[1]);
  assign mem_dq_oe = (st == S_WDRV) || (st == S_WHOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ack      <= 1'b0;
      rdata    <= '0;
      mem_addr <= '0;
      mem_dq_o <= '0;
      msk_q    <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE:
          if (!ack) begin
            if (sleep) st <= S_RET;
            else if (req) begin
              mem_addr <= addr;
              mem_dq_o <= wdata;
              msk_q    <= wr ? be : 2'b11;
              if (!wr) begin
                st  <= S_RD;
                cnt <= CW'(N_RD - 1);
              end else if (be == 2'b00) ack <= 1'b1;
              else st <= S_WLO;
            end
          end
        S_RET:
          if (!sleep) begin
            st  <= S_RECOV;
            cnt <= CW'(N_RDR - 1);
          end
        S_RECOV:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_RD:
          if (cnt == '0) begin
            rdata <= mem_dq_i;
            ack   <= 1'b1;
            st    <= S_RREL;
            cnt   <= CW'(N_HZ - 1);
          end else cnt <= cnt - 1'b1;
        S_RREL:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_WLO: begin
          st  <= S_WDRV;
          cnt <= CW'(N_WP - 2);
        end
        S_WDRV:
          if (cnt == '0) begin
            st  <= S_WHOLD;
            ack <= 1'b1;
          end else cnt <= cnt - 1'b1;
        S_WHOLD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R8
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R5
  drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n && !$past(mem_we_n));

  // R6
  write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_cs1_n && mem_lb_n && mem_ub_n && mem_dq_oe && $stable(mem_addr));

  // R4
  write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs1_n && mem_cs2 && mem_oe_n);

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs2 |-> mem_cs1_n && mem_we_n);

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  // expected cycle counts from 5 ns clock: 45/5, 45/5-1, 15/5, 45/5
  localparam int EXP_RD = 9, EXP_WE = 8, EXP_HZ = 3, EXP_RDR = 9;

  logic clk = 0, rst_n = 0, sleep = 0, req = 0, wr = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic ack, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .be(be), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: indexed by low address byte
  logic [15:0] mdl [0:255];
  logic [15:0] refm [0:255];
  initial for (int i = 0; i < 256; i++) begin mdl[i] = '0; refm[i] = '0; end

  wire rd_on = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
  assign mem_dq_i = rd_on ? {mem_ub_n ? 8'h00 : mdl[mem_addr[7:0]][15:8],
                             mem_lb_n ? 8'h00 : mdl[mem_addr[7:0]][7:0]} : 16'h0000;

  // scoreboard
  bit          q_rd  [$];
  logic [15:0] q_dat [$];

  bit pend = 0; logic [7:0] p_a; logic [15:0] p_d; logic [1:0] p_l;
  int we_len = 0, oe_len = 0, ack_len = 0, since_rd = 0, we_falls = 0;
  bit we_bad = 0, oe_bad = 0;
  logic [17:0] last_addr;

  always @(negedge clk) if (rst_n) begin
    // write commit in model
    if (!mem_we_n && !mem_cs1_n && mem_cs2) begin
      pend = 1; p_a = mem_addr[7:0]; p_d = mem_dq_o; p_l = ~{mem_ub_n, mem_lb_n};
    end else if (pend) begin
      if (p_l[0]) mdl[p_a][7:0]  = p_d[7:0];
      if (p_l[1]) mdl[p_a][15:8] = p_d[15:8];
      pend = 0;
    end
    // write enable window
    if (!mem_we_n) begin
      if (we_len == 0) begin
        we_falls++;
        chk(!mem_dq_oe, "R5 drive on first WE-low cycle", mem_dq_oe, 0);
      end else if (!mem_dq_oe) we_bad = 1;
      we_len++;
      last_addr = mem_addr;
    end else if (we_len > 0) begin
      chk(we_len == EXP_WE, "R4 WE low width", we_len, EXP_WE);
      chk(!we_bad, "R5 drive held during WE low", we_bad, 0);
      chk(mem_cs1_n && mem_lb_n && mem_ub_n, "R6 enables end together",
          {mem_cs1_n, mem_lb_n, mem_ub_n}, 3'b111);
      chk(mem_dq_oe && mem_addr == last_addr, "R6 address/data hold", {mem_dq_oe, mem_addr}, {1'b1, last_addr});
      we_len = 0; we_bad = 0;
    end
    // read window
    if (!mem_oe_n) begin
      if (mem_dq_oe || mem_lb_n || mem_ub_n || mem_cs1_n || !mem_cs2 || !mem_we_n) oe_bad = 1;
      oe_len++;
    end else if (oe_len > 0) begin
      chk(oe_len == EXP_RD, "R2 OE low width", oe_len, EXP_RD);
      chk(!oe_bad, "R2/R8 read pins, no pad drive", oe_bad, 0);
      oe_len = 0; oe_bad = 0; since_rd = 1;
    end else if (since_rd > 0) begin
      if (!mem_cs1_n) begin
        chk(since_rd > EXP_HZ, "R8 float gap after read", since_rd, EXP_HZ + 1);
        since_rd = 0;
      end else since_rd++;
    end
    // acknowledge
    if (ack) begin
      ack_len++;
      if (ack_len == 1) begin
        if (q_rd.size() == 0) chk(0, "R10 unexpected ack", 1, 0);
        else begin
          bit isr; logic [15:0] e;
          isr = q_rd.pop_front(); e = q_dat.pop_front();
          if (isr) chk(rdata == e, "R3 read data", rdata, e);
        end
      end
    end else if (ack_len > 0) begin
      chk(ack_len == 1, "R10 ack width", ack_len, 1);
      ack_len = 0;
    end
  end

  task automatic xfer(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    if (w) begin
      if (m[0]) refm[a[7:0]][7:0]  = d[7:0];
      if (m[1]) refm[a[7:0]][15:8] = d[15:8];
    end
    q_rd.push_back(!w); q_dat.push_back(refm[a[7:0]]);
    @(negedge clk);
    wr = w; addr = a; wdata = d; be = m; req = 1;
    do @(negedge clk); while (!ack);
    req = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_chk(input string tag);
    chk(mem_cs1_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !ack && mem_cs2,
        tag, {mem_cs1_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, ack, mem_cs2}, 8'b11111001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    idle_chk("R1 state during reset");
    rst_n = 1;
    @(negedge clk);
    idle_chk("R1 state after reset");

    xfer(1, 18'h00012, 16'hA5C3, 2'b11);
    xfer(0, 18'h00012, 16'h0, 2'b11);
    xfer(1, 18'h00012, 16'h1177, 2'b01);        // R4 lower lane only
    chk(mdl[8'h12] == 16'hA577, "R4 lower lane write", mdl[8'h12], 16'hA577);
    xfer(0, 18'h00012, 16'h0, 2'b11);
    xfer(1, 18'h3FF34, 16'hBEEF, 2'b10);        // R4 upper lane only
    xfer(0, 18'h3FF34, 16'h0, 2'b01);           // R2 mask ignored on read
    begin : zero_mask
      int f0;
      f0 = we_falls;
      xfer(1, 18'h00012, 16'hFFFF, 2'b00);      // R7
      chk(we_falls == f0, "R7 no WE on empty mask", we_falls - f0, 0);
    end
    xfer(0, 18'h00012, 16'h0, 2'b00);           // R7 contents unchanged, R2 both lanes
    idle_chk("R1 idle between accesses");

    // R9 retention
    sleep = 1;
    repeat (3) @(negedge clk);
    chk(!mem_cs2 && mem_cs1_n, "R9 retention pins", {mem_cs2, mem_cs1_n}, 2'b01);
    q_rd.push_back(1); q_dat.push_back(refm[8'h34]);
    wr = 0; addr = 18'h3FF34; be = 2'b11; req = 1;
    begin : hold_off
      bit quiet = 1;
      repeat (6) begin @(negedge clk); if (ack || !mem_cs1_n) quiet = 0; end
      chk(quiet, "R9 request waits during retention", quiet, 1);
    end
    sleep = 0;
    begin : recov
      int k = 0;
      do begin @(negedge clk); k++; end while (mem_cs1_n && k < 100);
      chk(k >= EXP_RDR + 1, "R9 recovery delay", k, EXP_RDR + 1);
    end
    do @(negedge clk); while (!ack);
    req = 0;
    repeat (3) @(negedge clk);
    xfer(1, 18'h00077, 16'h0F0F, 2'b11);
    xfer(0, 18'h00077, 16'h0, 2'b11);
    repeat (3) @(negedge clk);
    chk(q_rd.size() == 0, "R10 one ack per request", q_rd.size(), 0);
    idle_chk("R1 final idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule